// File: doc/BRIEF.md
# Digital Milliwatt Tone Generator

This block emits the standard 1 kHz digital milliwatt test tone as companded PCM codes, one code per 8 kHz frame. It can drive a PCM serial port in place of encoded audio. It moves through eight phase points of one sine cycle, at odd multiples of π/8, and advances one point for each frame strobe. A select input chooses between the mu-law and A-law code sets. The codes are fixed per phase and per law, so the block needs no arithmetic on samples.

The tone starts at the π/8 point on the first frame strobe after the enable is raised. Dropping the enable stops the tone at once and returns the phase to π/8. While the tone is stopped, the output holds the positive-zero code of the latched law. The law select is sampled only on frame strobes, so a code never mixes the two laws within a frame.

Top module: `dmw_tone_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no frame strobe yet, `pcm_code` is 8'hFF (mu-law positive zero) and the phase is at π/8.
- R2: While the tone is stopped, `pcm_code` is the positive-zero code of the latched law: 8'hFF for mu-law (`law_sel`=0) and 8'hD5 for A-law (`law_sel`=1).
- R3: While stopped, the first frame strobe that sees `tone_en` high starts the tone. From the next cycle, `pcm_code` shows the π/8 code of the law latched by that strobe.
- R4: With mu-law latched, successive frames give 8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E.
- R5: With A-law latched, successive frames give 8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4.
- R6: The phase, and with it `pcm_code`, changes only in the cycle after a frame strobe or after `tone_en` goes low. Between strobes the output holds.
- R7: The 3-bit phase wraps from 15π/8 back to π/8, so the ninth code of a run equals the first.
- R8: `law_sel` is latched only on a frame strobe. A change between strobes leaves `pcm_code` unchanged. At the next strobe the code moves to the next phase, in the new law.
- R9: `tone_en` low in any cycle gives the zero code from the next cycle and clears the phase. On re-enable, the tone waits for a frame strobe and restarts at π/8.
- R10: While the tone runs, bit 7 of `pcm_code` is 0 for the first four phases and 1 for the last four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | Single-cycle 8 kHz frame strobe |
| tone_en | input | 1 | Tone enable; low stops the tone and clears the phase |
| law_sel | input | 1 | Companding law: 0 mu-law, 1 A-law |
| pcm_code | output | 8 | Companded PCM code for the current frame |

## Verification
The assertions assume `frame_stb` is a pulse one clock wide, and that `tone_en` and `law_sel` change only between edges. The stimulus drives every input on the falling clock edge and never raises the strobe for more than one cycle. The assertions also take as given that a running tone has already seen a start strobe, so they check the phase step only on strobes made while the tone runs. The directed tasks start each scenario from a known stop, either through reset or by dropping `tone_en`, so the expected phase always has a known origin.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
   typedef enum logic {
      LAW_MU = 1'b0,
      LAW_A  = 1'b1
   } law_e;

   // Magnitude fields (chord and step) at the outer and inner phases of a half cycle
   localparam logic [6:0] MU_MAG_OUTER = 7'h1E;
   localparam logic [6:0] MU_MAG_INNER = 7'h0B;
   localparam logic [6:0] A_MAG_OUTER  = 7'h34;
   localparam logic [6:0] A_MAG_INNER  = 7'h21;

   localparam logic [7:0] MU_ZERO_CODE = 8'hFF;
   localparam logic [7:0] A_ZERO_CODE  = 8'hD5;

   function automatic logic [7:0] zero_code(law_e law);
      return (law == LAW_A) ? A_ZERO_CODE : MU_ZERO_CODE;
   endfunction
endpackage

// File: rtl/dmw_phase_seq.sv
module dmw_phase_seq #(
   parameter int PHASES = 8,
   localparam int PW = $clog2(PHASES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_stb,
   input  logic          tone_en,
   output logic [PW-1:0] phase,
   output logic          active
);
   localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= '0;
         active <= 1'b0;
      end else if (!tone_en) begin
         phase  <= '0;
         active <= 1'b0;
      end else if (frame_stb) begin
         if (!active) begin
            active <= 1'b1;
            phase  <= '0;
         end else if (phase == LAST) begin
            phase <= '0;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dmw_law_latch.sv
module dmw_law_latch
   import dmw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic law_sel,
   output law_e law_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)         law_q <= LAW_MU;
      else if (frame_stb) law_q <= law_e'(law_sel);
   end
endmodule

// File: rtl/dmw_code_map.sv
module dmw_code_map
   import dmw_pkg::*;
#(
   parameter int PW     = 3,
   parameter int CODE_W = 8,
   parameter bit FOLDED = 1'b1
) (
   input  law_e              law,
   input  logic [PW-1:0]     phase,
   input  logic              active,
   output logic [CODE_W-1:0] code
);
   logic [CODE_W-1:0] tone;

   generate
      if (FOLDED) begin : g_folded
         // Sign from the half cycle; magnitude mirrors around the half-cycle centre
         logic inner;
         logic [6:0] mag;
         always_comb begin
            inner = phase[1] ^ phase[0];
            if (law == LAW_A) mag = inner ? A_MAG_INNER  : A_MAG_OUTER;
            else              mag = inner ? MU_MAG_INNER : MU_MAG_OUTER;
            tone = {phase[PW-1], mag};
         end
      end else begin : g_table
         always_comb begin
            unique case ({law, phase})
               4'b0_000: tone = 8'h1E;
               4'b0_001: tone = 8'h0B;
               4'b0_010: tone = 8'h0B;
               4'b0_011: tone = 8'h1E;
               4'b0_100: tone = 8'h9E;
               4'b0_101: tone = 8'h8B;
               4'b0_110: tone = 8'h8B;
               4'b0_111: tone = 8'h9E;
               4'b1_000: tone = 8'h34;
               4'b1_001: tone = 8'h21;
               4'b1_010: tone = 8'h21;
               4'b1_011: tone = 8'h34;
               4'b1_100: tone = 8'hB4;
               4'b1_101: tone = 8'hA1;
               4'b1_110: tone = 8'hA1;
               default:  tone = 8'hB4;
            endcase
         end
      end
   endgenerate

   assign code = active ? tone : zero_code(law);
endmodule

// File: rtl/dmw_tone_gen.sv
module dmw_tone_gen
   import dmw_pkg::*;
#(
   parameter int PHASES = 8,
   parameter int CODE_W = 8,
   parameter bit FOLDED = 1'b1,
   localparam int PW = $clog2(PHASES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              tone_en,
   input  logic              law_sel,
   output logic [CODE_W-1:0] pcm_code
);
   if (PHASES != 8) begin : g_bad_phases
      $error("dmw_tone_gen: the tone is defined for exactly 8 phase points");
   end
   if (CODE_W != 8) begin : g_bad_width
      $error("dmw_tone_gen: companded codes are 8 bits wide");
   end

   logic [PW-1:0] phase_w;
   logic          active_w;
   law_e          law_w;

   dmw_phase_seq #(.PHASES(PHASES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .tone_en   (tone_en),
      .phase     (phase_w),
      .active    (active_w)
   );

   dmw_law_latch u_law (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .law_sel   (law_sel),
      .law_q     (law_w)
   );

   dmw_code_map #(.PW(PW), .CODE_W(CODE_W), .FOLDED(FOLDED)) u_map (
      .law    (law_w),
      .phase  (phase_w),
      .active (active_w),
      .code   (pcm_code)
   );
endmodule

// File: rtl/dmw_tone_chk.sv
module dmw_tone_chk #(
   parameter int PW     = 3,
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb,
   input logic              tone_en,
   input logic              law_sel,
   input logic [CODE_W-1:0] pcm_code,
   input logic [PW-1:0]     phase,
   input logic              active,
   input logic              law_q
);
   AST_START_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && tone_en && !active) |=> (active && phase == '0)); // R3

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && tone_en) |=> $stable(pcm_code)); // R6

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && tone_en && active) |=> (phase == PW'($past(phase) + 1'b1))); // R7

   AST_LAW_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> (law_q == $past(law_sel))); // R8

   AST_LAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(law_q)); // R8

   AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_en |=> (!active && phase == '0 && (pcm_code == 8'hFF || pcm_code == 8'hD5))); // R9

   AST_SIGN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (pcm_code[CODE_W-1] == phase[PW-1])); // R10
endmodule

bind dmw_tone_gen dmw_tone_chk #(.PW(PW), .CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_stb (frame_stb),
   .tone_en   (tone_en),
   .law_sel   (law_sel),
   .pcm_code  (pcm_code),
   .phase     (phase_w),
   .active    (active_w),
   .law_q     (law_w)
);

// File: tb/dmw_tone_gen_bench.sv
module dmw_tone_gen_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       tone_en = 1'b0;
   logic       law_sel = 1'b0;
   logic [7:0] pcm_code;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] mu_seq [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
   logic [7:0] a_seq  [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};

   always #(CLK_PERIOD/2) clk = ~clk;

   dmw_tone_gen u_dmw_tone_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .tone_en   (tone_en),
      .law_sel   (law_sel),
      .pcm_code  (pcm_code)
   );

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: pcm_code=%h expected=%h", req, got, exp);
      end
   endtask

   // one-cycle strobe; returns at the falling edge after the active edge
   task automatic pulse();
      @(negedge clk) frame_stb = 1'b1;
      @(negedge clk) frame_stb = 1'b0;
   endtask

   task automatic stop_tone();
      @(negedge clk) tone_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", pcm_code, 8'hFF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after release", pcm_code, 8'hFF);
   endtask

   task automatic t_mu_run();
      law_sel = 1'b0;
      tone_en = 1'b1;
      @(negedge clk);
      check("R3 enabled, no strobe yet", pcm_code, 8'hFF);
      for (int k = 0; k < 8; k++) begin
         pulse();
         check(k == 0 ? "R3 first code" : "R4 mu sequence", pcm_code, mu_seq[k]);
      end
      pulse();
      check("R7 wrap to first phase", pcm_code, mu_seq[0]);
   endtask

   task automatic t_hold();
      pulse();
      repeat (6) @(negedge clk);
      check("R6 hold between strobes", pcm_code, mu_seq[1]);
   endtask

   task automatic t_a_run();
      stop_tone();
      law_sel = 1'b1;
      tone_en = 1'b1;
      for (int k = 0; k < 8; k++) begin
         pulse();
         check("R5 A-law sequence", pcm_code, a_seq[k]);
         check("R10 sign bit", {7'd0, pcm_code[7]}, {7'd0, (k >= 4)});
      end
   endtask

   task automatic t_stopped_law();
      stop_tone();
      check("R2 A-law zero", pcm_code, 8'hD5);
      law_sel = 1'b0;
      repeat (2) @(negedge clk);
      check("R2 law not latched without strobe", pcm_code, 8'hD5);
      pulse();
      check("R2 mu-law zero after strobe", pcm_code, 8'hFF);
   endtask

   task automatic t_law_switch();
      law_sel = 1'b0;
      tone_en = 1'b1;
      repeat (3) pulse();
      check("R8 before switch", pcm_code, mu_seq[2]);
      law_sel = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 switch waits for strobe", pcm_code, mu_seq[2]);
      pulse();
      check("R8 next phase in new law", pcm_code, a_seq[3]);
   endtask

   task automatic t_stop_restart();
      pulse();
      check("R9 running before stop", pcm_code, a_seq[4]);
      @(negedge clk) tone_en = 1'b0;
      @(negedge clk);
      check("R9 zero next cycle", pcm_code, 8'hD5);
      tone_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 waits for strobe", pcm_code, 8'hD5);
      pulse();
      check("R9 restart at first phase", pcm_code, a_seq[0]);
      pulse();
      check("R9 continues after restart", pcm_code, a_seq[1]);
   endtask

   initial begin
      t_reset();
      t_mu_run();
      t_hold();
      t_a_run();
      t_stopped_law();
      t_law_switch();
      t_stop_restart();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule